// File: doc/BRIEF.md
# MMU Control Register Bank

This block holds the memory-management control state of a small processor core as five 32-bit registers mapped at the top of the address space: an entry-high register (virtual page number plus address-space ID), an entry-low register (physical page number plus page flags), a table-base register, a fault-address register and a control register. Software reads and writes them with single-word bus accesses, and only while the core is in privileged mode. A user-mode access to any of the five addresses returns zero, changes nothing, and raises a one-cycle violation pulse.

When the core signals an MMU or address-error exception, the block takes the faulting virtual address without any software action. The upper 22 address bits go into the page-number field of entry-high, and the whole address goes into the fault-address register. A load-entry command then copies the staged page number, ID and entry-low word onto a TLB write port. That port is registered and stays valid for one cycle.

Top module: `mmuCtlBank`

## Requirements
- R1: In privileged mode, a write to 0xFFFFFFF4 (entry low), 0xFFFFFFF8 (table base), 0xFFFFFFFC (fault address) or 0xFFFFFFE0 (control) stores all 32 data bits. A read of the same address returns the stored word combinationally, in the cycle of the read.
- R2: Entry-high sits at 0xFFFFFFF0. Bits 7:0 hold the address-space ID and bits 31:10 hold the virtual page number. Bits 9:8 always read as zero.
- R3: After reset, the control register reads zero in every bit except bit 8, whose value is left unspecified.
- R4: A user-mode access (privMode low) to any of the five addresses reads zero and leaves the register unchanged. It also drives accessFault high in the following cycle only.
- R5: When excValid is high, excAddr[31:10] is loaded into the page-number field of entry-high and excAddr into the fault-address register. Both values are visible to a read in the next cycle.
- R6: An exception leaves the address-space ID, entry-low, table base and control register unchanged.
- R7: If a software write to entry-high or to the fault-address register falls in the same cycle as an exception, the write is dropped entirely and the captured values remain.
- R8: When ldtlbReq is high, tlbWrEn is high in the next cycle only. During that cycle tlbVpn, tlbAsid and tlbPte carry the entry-high fields and the entry-low word as they stood at the edge that sampled the request.
- R9: An access to any other address reads zero, raises no accessFault and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-on or manual) |
| busValid | input | 1 | Bus access present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Word address of the access |
| busWdata | input | 32 | Write data |
| privMode | input | 1 | Core is in privileged mode |
| busRdata | output | 32 | Read data (combinational) |
| accessFault | output | 1 | One-cycle pulse after a user-mode access to a mapped register |
| excValid | input | 1 | MMU or address-error exception this cycle |
| excAddr | input | 32 | Faulting virtual address |
| ldtlbReq | input | 1 | Load-entry command |
| tlbWrEn | output | 1 | TLB write strobe |
| tlbVpn | output | 22 | Virtual page number for the TLB |
| tlbAsid | output | 8 | Address-space ID for the TLB |
| tlbPte | output | 32 | Entry-low word for the TLB |

## Verification
Read data is combinational. The bench drives a read on a falling edge and samples busRdata 1 ns later, in the same cycle. Writes and exception captures take effect at the next rising edge, so every check of their result is a read issued in a later cycle. accessFault and tlbWrEn come from registers and are due one cycle after their stimulus. The bench samples them 1 ns after that rising edge, and samples them again one cycle later to confirm that the pulse has ended.

// File: rtl/mmuCtlPkg.sv
package mmuCtlPkg;
  localparam logic [31:0] ADDR_HI   = 32'hFFFF_FFF0;
  localparam logic [31:0] ADDR_LO   = 32'hFFFF_FFF4;
  localparam logic [31:0] ADDR_BASE = 32'hFFFF_FFF8;
  localparam logic [31:0] ADDR_TEA  = 32'hFFFF_FFFC;
  localparam logic [31:0] ADDR_CTL  = 32'hFFFF_FFE0;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_HI, SEL_LO, SEL_BASE, SEL_TEA, SEL_CTL
  } regSelE;

  typedef struct packed {
    logic   wrHi;
    logic   wrLo;
    logic   wrBase;
    logic   wrTea;
    logic   wrCtl;
    logic   capExc;
    logic   loadTlb;
    regSelE rdSel;
  } strobeT;
endpackage

// File: rtl/mmuCtlCtrl.sv
module mmuCtlCtrl
  import mmuCtlPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              privMode,
  input  logic              excValid,
  input  logic              ldtlbReq,
  output strobeT            strobe,
  output logic              accessFault
);
  regSelE sel;
  logic   hit, granted, wrOk;

  always_comb begin
    unique case (busAddr)
      ADDR_HI:   sel = SEL_HI;
      ADDR_LO:   sel = SEL_LO;
      ADDR_BASE: sel = SEL_BASE;
      ADDR_TEA:  sel = SEL_TEA;
      ADDR_CTL:  sel = SEL_CTL;
      default:   sel = SEL_NONE;
    endcase
  end

  assign hit     = (sel != SEL_NONE);
  assign granted = busValid && privMode && hit;
  assign wrOk    = granted && busWrite;

  always_comb begin
    // exception capture has priority over software writes to hi / tea
    strobe.wrHi    = wrOk && (sel == SEL_HI) && !excValid;
    strobe.wrLo    = wrOk && (sel == SEL_LO);
    strobe.wrBase  = wrOk && (sel == SEL_BASE);
    strobe.wrTea   = wrOk && (sel == SEL_TEA) && !excValid;
    strobe.wrCtl   = wrOk && (sel == SEL_CTL);
    strobe.capExc  = excValid;
    strobe.loadTlb = ldtlbReq;
    strobe.rdSel   = (granted && !busWrite) ? sel : SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accessFault <= 1'b0;
    else       accessFault <= busValid && !privMode && hit;
  end
endmodule

// File: rtl/mmuCtlRegs.sv
module mmuCtlRegs
  import mmuCtlPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10,
  localparam int VPN_W  = DATA_W - VPN_LSB,
  localparam int GAP_W  = VPN_LSB - ASID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] excAddr,
  output logic [DATA_W-1:0] busRdata,
  output logic              tlbWrEn,
  output logic [VPN_W-1:0]  tlbVpn,
  output logic [ASID_W-1:0] tlbAsid,
  output logic [DATA_W-1:0] tlbPte
);
  logic [VPN_W-1:0]  vpnQ;
  logic [ASID_W-1:0] asidQ;
  logic [DATA_W-1:0] loQ, baseQ, teaQ, ctlQ;
  logic [DATA_W-1:0] hiView;

  generate
    if (GAP_W > 0) begin : gGap
      assign hiView = {vpnQ, {GAP_W{1'b0}}, asidQ};
    end else begin : gNoGap
      assign hiView = {vpnQ, asidQ};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnQ  <= '0;
      asidQ <= '0;
      loQ   <= '0;
      baseQ <= '0;
      teaQ  <= '0;
      ctlQ  <= '0;
    end else begin
      if (strobe.capExc) begin
        vpnQ <= excAddr[DATA_W-1:VPN_LSB];
        teaQ <= excAddr;
      end
      if (strobe.wrHi) begin
        vpnQ  <= busWdata[DATA_W-1:VPN_LSB];
        asidQ <= busWdata[ASID_W-1:0];
      end
      if (strobe.wrTea)  teaQ  <= busWdata;
      if (strobe.wrLo)   loQ   <= busWdata;
      if (strobe.wrBase) baseQ <= busWdata;
      if (strobe.wrCtl)  ctlQ  <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbWrEn <= 1'b0;
      tlbVpn  <= '0;
      tlbAsid <= '0;
      tlbPte  <= '0;
    end else begin
      tlbWrEn <= strobe.loadTlb;
      if (strobe.loadTlb) begin
        tlbVpn  <= vpnQ;
        tlbAsid <= asidQ;
        tlbPte  <= loQ;
      end
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_HI:   busRdata = hiView;
      SEL_LO:   busRdata = loQ;
      SEL_BASE: busRdata = baseQ;
      SEL_TEA:  busRdata = teaQ;
      SEL_CTL:  busRdata = ctlQ;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mmuCtlBank.sv
module mmuCtlBank
  import mmuCtlPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10,
  localparam int VPN_W  = DATA_W - VPN_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              privMode,
  output logic [DATA_W-1:0] busRdata,
  output logic              accessFault,
  input  logic              excValid,
  input  logic [DATA_W-1:0] excAddr,
  input  logic              ldtlbReq,
  output logic              tlbWrEn,
  output logic [VPN_W-1:0]  tlbVpn,
  output logic [ASID_W-1:0] tlbAsid,
  output logic [DATA_W-1:0] tlbPte
);
  strobeT strobe;

  mmuCtlCtrl #(.ADDR_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .privMode(privMode), .excValid(excValid),
    .ldtlbReq(ldtlbReq), .strobe(strobe), .accessFault(accessFault)
  );

  mmuCtlRegs #(.DATA_W(DATA_W), .ASID_W(ASID_W), .VPN_LSB(VPN_LSB)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .excAddr(excAddr), .busRdata(busRdata), .tlbWrEn(tlbWrEn),
    .tlbVpn(tlbVpn), .tlbAsid(tlbAsid), .tlbPte(tlbPte)
  );
endmodule

// File: rtl/mmuCtlBankChk.sv
module mmuCtlBankChk
  import mmuCtlPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ASID_W  = 8,
  parameter int VPN_LSB = 10,
  localparam int VPN_W  = DATA_W - VPN_LSB
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [DATA_W-1:0] busAddr,
  input logic              privMode,
  input logic [DATA_W-1:0] busRdata,
  input logic              accessFault,
  input logic              excValid,
  input logic [DATA_W-1:0] excAddr,
  input logic              ldtlbReq,
  input logic              tlbWrEn,
  input logic [VPN_W-1:0]  tlbVpn
);
  logic mapped, userHit;
  assign mapped  = (busAddr == ADDR_HI) || (busAddr == ADDR_LO) ||
                   (busAddr == ADDR_BASE) || (busAddr == ADDR_TEA) ||
                   (busAddr == ADDR_CTL);
  assign userHit = busValid && !privMode && mapped;

  a_r4_fault_after_user: assert property (@(posedge clk) disable iff (!rstN)
    userHit |=> accessFault);

  a_r9_no_stray_fault: assert property (@(posedge clk) disable iff (!rstN)
    !userHit |=> !accessFault);

  a_r4_user_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !privMode) |-> (busRdata == '0));

  a_r8_tlb_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ldtlbReq |=> tlbWrEn);

  a_r8_tlb_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ldtlbReq |=> !tlbWrEn);

  a_r5_vpn_to_tlb: assert property (@(posedge clk) disable iff (!rstN)
    excValid ##1 (ldtlbReq && !excValid) |=>
      (tlbVpn == $past(excAddr[DATA_W-1:VPN_LSB], 2)));
endmodule

bind mmuCtlBank mmuCtlBankChk #(.DATA_W(DATA_W), .ASID_W(ASID_W), .VPN_LSB(VPN_LSB)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .privMode(privMode), .busRdata(busRdata),
  .accessFault(accessFault), .excValid(excValid), .excAddr(excAddr),
  .ldtlbReq(ldtlbReq), .tlbWrEn(tlbWrEn), .tlbVpn(tlbVpn)
);

// File: tb/sim_mmuCtlBank.sv
`timescale 1ns/1ps
module sim_mmuCtlBank;
  localparam logic [31:0] A_HI = 32'hFFFF_FFF0, A_LO = 32'hFFFF_FFF4,
                          A_BASE = 32'hFFFF_FFF8, A_TEA = 32'hFFFF_FFFC,
                          A_CTL = 32'hFFFF_FFE0;
  localparam logic [31:0] HI_MASK = 32'hFFFF_FCFF;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busWrite = 0, privMode = 0, excValid = 0, ldtlbReq = 0;
  logic [31:0] busAddr = 0, busWdata = 0, excAddr = 0;
  logic [31:0] busRdata, tlbPte;
  logic accessFault, tlbWrEn;
  logic [21:0] tlbVpn;
  logic [7:0] tlbAsid;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmuCtlBank u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .privMode(privMode),
    .busRdata(busRdata), .accessFault(accessFault), .excValid(excValid),
    .excAddr(excAddr), .ldtlbReq(ldtlbReq), .tlbWrEn(tlbWrEn),
    .tlbVpn(tlbVpn), .tlbAsid(tlbAsid), .tlbPte(tlbPte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle; returns combinational read data and the fault seen after the edge
  task automatic busOp(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                       input logic priv, output logic [31:0] rd, output logic flt);
    @(negedge clk);
    busValid = 1; busWrite = wr; busAddr = addr; busWdata = data; privMode = priv;
    #1 rd = busRdata;
    @(posedge clk);
    #1 flt = accessFault;
    busValid = 0; busWrite = 0; privMode = 0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'h0000_0101 << (i % 24));
  endfunction

  initial begin
    logic [31:0] rd, v;
    logic flt;
    logic [31:0] addrs [4] = '{A_LO, A_BASE, A_TEA, A_CTL};
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R3 reset value of control, bit 8 masked
    busOp(0, A_CTL, 0, 1, rd, flt);
    check("R3 ctl reset", rd & ~32'h100, 32'h0);

    // R1 full-width registers, several patterns
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 4; k++) busOp(1, addrs[k], pat(i + k), 1, rd, flt);
      for (int k = 0; k < 4; k++) begin
        busOp(0, addrs[k], 0, 1, rd, flt);
        check("R1 readback", rd, pat(i + k));
      end
    end

    // R2 entry-high layout
    for (int i = 0; i < 6; i++) begin
      v = ~pat(i);
      busOp(1, A_HI, v, 1, rd, flt);
      busOp(0, A_HI, 0, 1, rd, flt);
      check("R2 hi layout", rd, v & HI_MASK);
    end

    // R4 user mode: read zero, write ignored, one-cycle fault
    busOp(1, A_BASE, 32'h1234_5678, 1, rd, flt);
    busOp(0, A_BASE, 0, 0, rd, flt);
    check("R4 user read zero", rd, 0);
    check("R4 fault pulse", {31'b0, flt}, 1);
    busOp(1, A_BASE, 32'hDEAD_BEEF, 0, rd, flt);
    check("R4 fault on write", {31'b0, flt}, 1);
    @(posedge clk); #1 check("R4 fault ends", {31'b0, accessFault}, 0);
    busOp(0, A_BASE, 0, 1, rd, flt);
    check("R4 write ignored", rd, 32'h1234_5678);
    check("R4 no fault priv", {31'b0, flt}, 0);

    // R9 unmapped address
    busOp(1, 32'hFFFF_FFE4, 32'hFFFF_FFFF, 0, rd, flt);
    check("R9 no fault", {31'b0, flt}, 0);
    busOp(0, 32'hFFFF_FFE4, 0, 1, rd, flt);
    check("R9 read zero", rd, 0);
    busOp(1, 32'h0000_0FF8, 32'h0BAD_0BAD, 1, rd, flt);
    busOp(0, A_BASE, 0, 1, rd, flt);
    check("R9 base unchanged", rd, 32'h1234_5678);

    // R5 / R6 exception capture
    busOp(1, A_HI, 32'h0000_005A, 1, rd, flt);
    busOp(1, A_LO, 32'hC0DE_0001, 1, rd, flt);
    busOp(1, A_CTL, 32'h0000_0005, 1, rd, flt);
    for (int i = 0; i < 4; i++) begin
      v = pat(i + 10);
      @(negedge clk); excValid = 1; excAddr = v;
      @(posedge clk); #1 excValid = 0;
      busOp(0, A_HI, 0, 1, rd, flt);
      check("R5 vpn capture", rd, (v & 32'hFFFF_FC00) | 32'h5A);
      check("R6 asid kept", rd & 32'hFF, 32'h5A);
      busOp(0, A_TEA, 0, 1, rd, flt);
      check("R5 tea capture", rd, v);
    end
    busOp(0, A_LO, 0, 1, rd, flt);
    check("R6 lo kept", rd, 32'hC0DE_0001);
    busOp(0, A_BASE, 0, 1, rd, flt);
    check("R6 base kept", rd, 32'h1234_5678);
    busOp(0, A_CTL, 0, 1, rd, flt);
    check("R6 ctl kept", rd, 32'h0000_0005);

    // R7 collision: exception wins over software write
    @(negedge clk);
    excValid = 1; excAddr = 32'hABCD_E7FF;
    busValid = 1; busWrite = 1; privMode = 1; busAddr = A_HI; busWdata = 32'h1111_11EE;
    @(posedge clk); #1 excValid = 0; busValid = 0; busWrite = 0;
    busOp(0, A_HI, 0, 1, rd, flt);
    check("R7 hi collision", rd, 32'hABCD_E45A);
    @(negedge clk);
    excValid = 1; excAddr = 32'h7777_1234;
    busValid = 1; busWrite = 1; privMode = 1; busAddr = A_TEA; busWdata = 32'h2222_2222;
    @(posedge clk); #1 excValid = 0; busValid = 0; busWrite = 0;
    busOp(0, A_TEA, 0, 1, rd, flt);
    check("R7 tea collision", rd, 32'h7777_1234);

    // R8 load-entry port
    busOp(1, A_HI, 32'h8040_2C3C, 1, rd, flt);
    busOp(1, A_LO, 32'h0F0F_A5A5, 1, rd, flt);
    @(negedge clk); ldtlbReq = 1;
    @(posedge clk); #1 ldtlbReq = 0;
    check("R8 wr strobe", {31'b0, tlbWrEn}, 1);
    check("R8 vpn", {10'b0, tlbVpn}, 32'h8040_2C3C >> 10);
    check("R8 asid", {24'b0, tlbAsid}, 32'h3C);
    check("R8 pte", tlbPte, 32'h0F0F_A5A5);
    @(posedge clk); #1 check("R8 strobe ends", {31'b0, tlbWrEn}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule